// File: doc/BRIEF.md
# Dual-Clock Frequency Comparator

This block judges whether a clock under test runs fast enough relative to a trusted reference. Two down-counters are loaded with programmable seeds and started together: one advances on ticks of the selected reference source and the other on ticks of the selected test source. The reference counter marks out a window of fixed length. The test counter must run out before that window closes. If it does not, a sticky frequency-error flag is set and an interrupt request is raised. After every window the two counters reload and a new comparison starts. This repeats for as long as the block is enabled.

Clock sources are modelled as single-cycle clock-enable lines, all sampled on one system clock `clk`. A 4-bit code picks one line for each counter. The test selection is guarded by a 4-bit key. The completion of the test counter reaches the decision logic through a synchronizer chain, as it would when it crosses from its own domain into the reference domain. Software programs the block and reads its state through a small word-addressed register port. Writes are synchronous and reads are combinational.

Top module: `dcmp_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the error flag is clear and `irq_o` is low.
- R2: The register map is as follows. Address 0 is control: bit 0 enable, bits 7:4 reference select, bits 11:8 test select, bits 15:12 test key, and it reads back as written. Address 1 takes the reference seed in bits 15:0 and reads {reference live count, reference seed}. Address 2 does the same for the test counter. Address 3 reads the error flag in bit 0.
- R3: While enable is 0, each counter holds its seed, and a seed write shows up as the live count one cycle later.
- R4: Reference select codes 0..3 pick clock-enable line 0..3. Codes 4..15 are reserved and give no ticks, so no window ever ends and no error is raised.
- R5: When the key equals 0xA, the test select code picks the line, and codes 4..15 give no ticks. With any other key, the test counter uses line 0 whatever its select code.
- R6: A window ends on the reference tick that brings the count from 1 to 0, which is the seed-th tick. A seed of 0 behaves like a seed of 1.
- R7: When a window ends, the error flag is set unless the final test tick came at least 3 clk cycles before the final reference tick. The 3 cycles are the synchronizer stages plus one.
- R8: After its seed-th tick, the test counter stays at 0 and gives exactly one completion pulse until the next reload.
- R9: At every window end, both counters reload their seeds and a new comparison starts.
- R10: The error flag is sticky and `irq_o` follows it. Writing 1 to bit 0 of address 3 clears it, and writing 0 there has no effect.
- R11: Clearing enable reloads both counters and drops any comparison in progress. It leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_en | input | NREF | Candidate reference tick lines |
| tst_clk_en | input | NTST | Candidate test tick lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq_o | output | 1 | Frequency-error interrupt request |

## Verification
A counter that decrements wrongly or fails to reload shows up within one window in two ways: the live counts at addresses 1 and 2 go wrong, and the pass or fail verdict on the error flag becomes wrong. A synchronizer chain that is too short or too long moves the pass/fail boundary by one cycle. For this reason the seeds are set so that the test counter finishes exactly 3 and exactly 2 cycles before the reference counter does, and both cases are checked. Wrong source decoding changes the tick rate, so the verdict flips within a few dozen cycles. Reserved codes and a wrong key are checked the same way.

// File: rtl/dcmp_pkg.sv
// Package: shared constants and the control register layout for the
// dual-clock frequency comparator. Assumes a 2-bit word address.
package dcmp_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RSEED = 2'd1;
    localparam logic [1:0] ADDR_TSEED = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;
    localparam logic [3:0] KEY_UNLOCK = 4'hA;

    typedef struct packed {
        logic [3:0] key;
        logic [3:0] tst_sel;
        logic [3:0] ref_sel;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/dcmp_src_sel.sv
// Source selector: turns a 4-bit code into one tick line out of N.
// Codes at or above N are reserved and give no ticks. With KEYED=1 the
// code is honoured only under the unlock key; otherwise DEFAULT_IDX is used.
// Assumes N <= 16 and DEFAULT_IDX < N.
module dcmp_src_sel import dcmp_pkg::*; #(
    parameter int N = 4,
    parameter int DEFAULT_IDX = 0,
    parameter bit KEYED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   sel,
    input  logic [3:0]   key,
    input  logic [N-1:0] lines,
    output logic         tick
);
    logic [3:0] eff_sel;

    generate
        if (KEYED) begin : g_keyed
            // Purpose: apply the key guard to the select code
            always_comb eff_sel = (key == KEY_UNLOCK) ? sel : 4'(DEFAULT_IDX);
        end else begin : g_plain
            logic key_unused;
            assign key_unused = ^key;
            // Purpose: pass the select code through unchanged
            always_comb eff_sel = sel;
        end
    endgenerate

    // Purpose: pick the addressed line; reserved codes yield no tick
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(eff_sel) == i) tick = lines[i];
        end
    end

    // R4/R5: a reserved effective code never produces a tick
    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(eff_sel) >= N) |-> !tick);
endmodule

// File: rtl/dcmp_downcnt.sv
// Seeded down-counter advanced by a tick enable. 'last' flags the tick that
// takes the count to zero; after that the counter stays at zero ('spent')
// until reload. Reload has priority and copies the seed in.
module dcmp_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         reload,
    input  logic         tick,
    input  logic [W-1:0] seed,
    output logic [W-1:0] cnt,
    output logic         last,
    output logic         spent
);
    // Purpose: flag the final tick of this run
    always_comb last = run && tick && !spent && (cnt <= W'(1));

    // Purpose: load, count down, or hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (reload) begin
            cnt   <= seed;
            spent <= 1'b0;
        end else if (last) begin
            cnt   <= '0;
            spent <= 1'b1;
        end else if (run && tick && !spent) begin
            cnt   <= cnt - 1'b1;
        end
    end

    // R8: once spent the count stays at zero until a reload
    a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        spent && !reload |=> (cnt == '0) && spent);
    // R8: the completion pulse is one cycle wide when no reload follows
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        last && !reload |=> !last);
    // R3: after a reload the count equals the seed that was presented
    a_r3_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> cnt == $past(seed));
endmodule

// File: rtl/dcmp_sync.sv
// Multi-flop synchronizer for a level, with a synchronous clear driven from
// the destination domain. STAGES sets the depth (at least 2).
module dcmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the level through the chain, emptied on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) chain <= '0;
        else               chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    // R7: a clear always empties the output stage
    a_r7_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);
endmodule

// File: rtl/dcmp_top.sv
// Dual-clock frequency comparator top. Holds the register port, the two
// source selectors, the two counters and the verdict logic. The test
// counter's completion is synchronized into the reference domain. The
// verdict is made at each reference window end, and that event also
// restarts both counters. All source clocks are modelled as tick enables on clk.
module dcmp_top import dcmp_pkg::*; #(
    parameter int NREF = 4,
    parameter int NTST = 4,
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2,
    parameter int TST_DEFAULT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREF-1:0] ref_clk_en,
    input  logic [NTST-1:0] tst_clk_en,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    output logic            irq_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] ref_seed, tst_seed, ref_cnt, tst_cnt;
    logic             err;
    logic             ref_tick, tst_tick, ref_last, tst_last;
    logic             tst_spent, ref_spent_unused, tst_hit_s;
    logic             win_end, reload, err_set, err_clr;
    logic             wdata_unused;

    assign wdata_unused = ^cfg_wdata[31:16];

    dcmp_src_sel #(.N(NREF), .DEFAULT_IDX(0), .KEYED(1'b0)) i_ref_sel (
        .clk(clk), .rst_n(rst_n), .sel(ctrl.ref_sel), .key(4'h0),
        .lines(ref_clk_en), .tick(ref_tick));

    dcmp_src_sel #(.N(NTST), .DEFAULT_IDX(TST_DEFAULT), .KEYED(1'b1)) i_tst_sel (
        .clk(clk), .rst_n(rst_n), .sel(ctrl.tst_sel), .key(ctrl.key),
        .lines(tst_clk_en), .tick(tst_tick));

    // Purpose: window end, restart and verdict decisions in the reference domain
    always_comb begin
        win_end = ref_last;
        reload  = !ctrl.en || win_end;
        err_set = win_end && !tst_hit_s;
        err_clr = cfg_we && (cfg_addr == ADDR_STAT) && cfg_wdata[0];
    end

    dcmp_downcnt #(.W(CNT_W)) i_ref_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en), .reload(reload), .tick(ref_tick),
        .seed(ref_seed), .cnt(ref_cnt), .last(ref_last), .spent(ref_spent_unused));

    dcmp_downcnt #(.W(CNT_W)) i_tst_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en), .reload(reload), .tick(tst_tick),
        .seed(tst_seed), .cnt(tst_cnt), .last(tst_last), .spent(tst_spent));

    dcmp_sync #(.STAGES(SYNC_STAGES)) i_hit_sync (
        .clk(clk), .rst_n(rst_n), .clr(reload), .d(tst_spent), .q(tst_hit_s));

    // Purpose: register writes and the sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            ref_seed <= '0;
            tst_seed <= '0;
            err      <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == ADDR_CTRL) begin
                ctrl.en      <= cfg_wdata[0];
                ctrl.ref_sel <= cfg_wdata[7:4];
                ctrl.tst_sel <= cfg_wdata[11:8];
                ctrl.key     <= cfg_wdata[15:12];
            end
            if (cfg_we && cfg_addr == ADDR_RSEED) ref_seed <= cfg_wdata[CNT_W-1:0];
            if (cfg_we && cfg_addr == ADDR_TSEED) tst_seed <= cfg_wdata[CNT_W-1:0];
            err <= err_set || (err && !err_clr);
        end
    end

    // Purpose: combinational register read-back
    always_comb begin
        unique case (cfg_addr)
            ADDR_CTRL:  cfg_rdata = {16'h0, ctrl.key, ctrl.tst_sel, ctrl.ref_sel, 3'b000, ctrl.en};
            ADDR_RSEED: cfg_rdata = {16'(ref_cnt), 16'(ref_seed)};
            ADDR_TSEED: cfg_rdata = {16'(tst_cnt), 16'(tst_seed)};
            default:    cfg_rdata = {31'h0, err};
        endcase
    end

    assign irq_o = err;

    // R10: the flag stays set unless a clearing write arrives
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err && !err_clr |=> err);
    // R7: the flag only rises on a window end
    a_r7_set_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(win_end));
    // R11: with enable low no window can end
    a_r11_idle_no_window: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !win_end);
    // R10: interrupt line tracks the flag
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (cfg_rdata[0] || cfg_addr != ADDR_STAT ? err : 1'b0));
endmodule

// File: tb/test_dcmp_top.sv
// Bench for dcmp_top: a vector table of configurations with expected
// verdicts, then directed tests for reset, timing boundary, hold/restart,
// disable and clearing.
module test_dcmp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_en, tst_en;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_o;
    int unsigned cyc = 0;
    int          n_run = 0, n_fail = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    dcmp_top i_dcmp_top (
        .clk(clk), .rst_n(rst_n), .ref_clk_en(ref_en), .tst_clk_en(tst_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_o(irq_o));

    // Line i ticks once every i+1 cycles on both sides
    always @(posedge clk) cyc <= cyc + 1;
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            ref_en[i] = (cyc % (i + 1)) == 0;
            tst_en[i] = (cyc % (i + 1)) == 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [31:0] ctrlw(input logic [3:0] rs, input logic [3:0] ts,
                                          input logic [3:0] k, input logic en);
        return {16'h0, k, ts, rs, 3'b000, en};
    endfunction

    task automatic start(input logic [3:0] rs, input logic [3:0] ts, input logic [3:0] k,
                         input logic [15:0] rseed, input logic [15:0] tseed);
        wr(2'd0, ctrlw(rs, ts, k, 1'b0));
        wr(2'd3, 32'h1);
        wr(2'd1, {16'h0, rseed});
        wr(2'd2, {16'h0, tseed});
        wr(2'd0, ctrlw(rs, ts, k, 1'b1));
    endtask

    // {ref_sel, tst_sel, key, ref_seed, tst_seed, expected error}
    localparam logic [47:0] VEC [8] = '{
        {4'd0, 4'd0, 4'hA, 16'd20, 16'd10, 4'd0},  // R6 R7 pass
        {4'd0, 4'd1, 4'hA, 16'd20, 16'd15, 4'd1},  // R7 test too slow
        {4'd1, 4'd1, 4'hA, 16'd20, 16'd15, 4'd0},  // R4 slower reference line
        {4'd0, 4'd3, 4'hA, 16'd50, 16'd5,  4'd0},  // R5 keyed line 3
        {4'd0, 4'd2, 4'hA, 16'd10, 16'd5,  4'd1},  // R5 keyed line 2 fails
        {4'd0, 4'd5, 4'hA, 16'd50, 16'd1,  4'd1},  // R5 reserved test code
        {4'd0, 4'd3, 4'h5, 16'd30, 16'd10, 4'd0},  // R5 wrong key -> line 0
        {4'd6, 4'd0, 4'hA, 16'd5,  16'd100, 4'd0}  // R4 reserved reference code
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, rv); chk("R1 ctrl", rv, 32'h0);
        rd(2'd1, rv); chk("R1 ref seed/count", rv, 32'h0);
        rd(2'd3, rv); chk("R1 error", rv, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2 control read-back
        wr(2'd0, ctrlw(4'h3, 4'h2, 4'hA, 1'b0));
        rd(2'd0, rv); chk("R2 ctrl readback", rv, 32'h0000A230);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            start(VEC[v][47:44], VEC[v][43:40], VEC[v][39:36], VEC[v][35:20], VEC[v][19:4]);
            repeat (200) @(posedge clk);
            rd(2'd3, rv); chk($sformatf("R7 vector %0d error", v), rv, {28'h0, VEC[v][3:0]});
            chk($sformatf("R10 vector %0d irq", v), {31'h0, irq_o}, {28'h0, VEC[v][3:0]});
            if (VEC[v][47:44] >= 4) begin
                rd(2'd1, rv); chk("R4 reserved ref never counts", rv, {VEC[v][35:20], VEC[v][35:20]});
            end
        end

        // R7 boundary: test finishes 3 cycles before the window end -> pass
        start(4'd0, 4'd0, 4'hA, 16'd10, 16'd7);
        repeat (60) @(posedge clk);
        rd(2'd3, rv); chk("R7 gap of 3 passes", rv, 32'h0);
        // R7 boundary: 2 cycles is too late -> error
        start(4'd0, 4'd0, 4'hA, 16'd10, 16'd8);
        repeat (60) @(posedge clk);
        rd(2'd3, rv); chk("R7 gap of 2 fails", rv, 32'h1);
        // R6 seed 0 behaves as 1: ref window of 1 tick beats any test
        start(4'd0, 4'd0, 4'hA, 16'd0, 16'd1);
        repeat (20) @(posedge clk);
        rd(2'd3, rv); chk("R6 zero seed window", rv, 32'h1);

        // R8 hold at zero, R9 restart reload
        start(4'd3, 4'd0, 4'hA, 16'd20, 16'd5);
        repeat (40) @(posedge clk);
        rd(2'd2, rv); chk("R8 test count held at zero", {16'h0, rv[31:16]}, 32'h0);
        repeat (41) @(posedge clk);
        rd(2'd2, rv);
        chk("R9 test count reloaded after window", {31'h0, (rv[31:16] >= 1 && rv[31:16] <= 5)}, 32'h1);
        rd(2'd3, rv); chk("R9 repeated windows pass", rv, 32'h0);

        // R11 disable reloads; error survives; R10 write-0 no effect, write-1 clears
        start(4'd0, 4'd1, 4'hA, 16'd10, 16'd9);
        repeat (50) @(posedge clk);
        wr(2'd0, ctrlw(4'd0, 4'd1, 4'hA, 1'b0));
        rd(2'd1, rv); chk("R11 ref reloaded on disable", rv, 32'h000A000A);
        rd(2'd2, rv); chk("R3 test holds seed while idle", rv, 32'h00090009);
        rd(2'd3, rv); chk("R11 error kept over disable", rv, 32'h1);
        wr(2'd3, 32'h0);
        rd(2'd3, rv); chk("R10 write 0 keeps error", rv, 32'h1);
        wr(2'd3, 32'h1);
        rd(2'd3, rv); chk("R10 write 1 clears error", rv, 32'h0);
        chk("R10 irq cleared", {31'h0, irq_o}, 32'h0);
        wr(2'd1, 32'h0000_0033);
        rd(2'd1, rv); chk("R3 seed write tracked while idle", rv, 32'h00330033);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule